// File: doc/BRIEF.md
# Memory Protection Region Checker

This block decides, for every memory access, whether it may proceed. Software programs a small set of address regions through a five-register interface. Each region has a base, a power-of-two size, eight equal slices that can be switched off one by one, a three-bit permission code and an execute-never flag. The block compares each access against every enabled region in parallel and returns a permit or fault answer in the same cycle. The access is described by its address and three flags: write, instruction fetch and privileged.

When several regions cover the same address, the one with the highest number decides. An access that falls outside every region faults unless the unit is off, or unless it is privileged and the background option is on. Software can also keep the unit out of the way while a hard-fault or NMI handler runs. Register writes land on the rising clock edge. Reads and access decisions are combinational.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset, the control register and the region number register read 0, and every attribute field of every region reads 0. While control bit 0 is 0, every access is permitted.
- R2: The type register (select 0) reads the region count in bits [15:8] and 0 in every other bit, including the separate-maps flag in bit 0.
- R3: In the control register (select 1), bit 0 enables checking. Bit 1 keeps checking active for accesses flagged as inside a fault handler. Bit 2 enables the privileged background map. A read returns these three bits, with all higher bits 0.
- R4: The base register is select 3, and the region number register is select 2. A write to the base register stores address bits [31:5]. If bit 4 of the write is 1, bits [3:0] choose the region and are copied into the region number register. If bit 4 is 0, the region number register chooses the region. An index at or above the region count changes no region. A base read returns the stored address bits with the region number in bits [3:0].
- R5: The attribute register is select 4 and acts on the region named by the region number register. Its fields are: execute-never in bit 28, permission code in [26:24], slice-disable mask in [15:8], SIZE in [5:1] and enable in bit 0. All other bits read 0.
- R6: A region covers 2^(SIZE+1) bytes, starting at the base with its low SIZE+1 bits cleared. A region with SIZE below 4 never matches.
- R7: A region is divided into eight equal slices. An address in slice j matches only when bit j of the disable mask is 0.
- R8: Permission code for privileged and unprivileged accesses: 000 no access for either; 001 privileged read/write, unprivileged none; 010 privileged read/write, unprivileged read; 011 read/write for both; 100 no access for either; 101 privileged read, unprivileged none; 110 and 111 read for both.
- R9: An instruction fetch that hits a region with execute-never set faults, whatever the permission code.
- R10: When more than one enabled region matches, the highest-numbered region decides.
- R11: With checking on, an access that matches no region faults. The exception is a privileged access while control bit 2 is 1, which is permitted.
- R12: An access flagged as inside a fault handler is permitted when control bit 1 is 0. When bit 1 is 1, it is checked like any other access.
- R13: An instruction fetch needs read permission and ignores the write flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 3 | Register select: 0 type, 1 control, 2 region number, 3 base, 4 attributes |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | Access is a write |
| acc_fetch | input | 1 | Access is an instruction fetch |
| acc_priv | input | 1 | Access is privileged |
| acc_in_handler | input | 1 | Access is made from a hard-fault or NMI handler |
| acc_permit | output | 1 | 1 permits the access, 0 signals a fault |

## Verification
The properties assume that the access flags and register strobes hold defined values whenever reset is released. They also assume that at most one register write arrives per cycle, so the value written to the control or base register can be read back one cycle later. The bench changes every input on the falling edge and leaves it unchanged through the following rising edge. It samples outputs only after the combinational paths have settled. It never drives a write and an access decision that depend on each other in the same cycle.

// File: rtl/mpu_guard_pkg.sv
// Shared types and the permission table for the memory protection checker.
// Assumes: permission code encoding as listed in the brief (R8).
package mpu_guard_pkg;

    typedef enum logic [2:0] {
        SEL_TYPE = 3'd0,
        SEL_CTRL = 3'd1,
        SEL_RNUM = 3'd2,
        SEL_BASE = 3'd3,
        SEL_ATTR = 3'd4
    } reg_sel_e;

    // Smallest SIZE code that gives a usable (32-byte) region
    localparam logic [4:0] MIN_SIZE_CODE = 5'd4;

    typedef struct packed {
        logic [26:0] base;
        logic        xn;
        logic [2:0]  ap;
        logic [7:0]  srd;
        logic [4:0]  size;
        logic        en;
    } region_t;

    // Returns {may_read, may_write} for a permission code and privilege level
    function automatic logic [1:0] ap_rights(input logic [2:0] ap, input logic priv);
        logic [1:0] r;
        case (ap)
            3'b001:         r = priv ? 2'b11 : 2'b00;
            3'b010:         r = priv ? 2'b11 : 2'b10;
            3'b011:         r = 2'b11;
            3'b101:         r = priv ? 2'b10 : 2'b00;
            3'b110, 3'b111: r = 2'b10;
            default:        r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mpu_region_slot.sv
// One protection region: holds its programmed fields and reports whether the
// current access address falls in an enabled slice of it.
// Assumes: field writes come from the top decode, at most one kind per cycle.
module mpu_region_slot
    import mpu_guard_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        base_we,
    input  logic        attr_we,
    input  logic [26:0] base_d,
    input  logic        xn_d,
    input  logic [2:0]  ap_d,
    input  logic [7:0]  srd_d,
    input  logic [4:0]  size_d,
    input  logic        en_d,
    input  logic [31:0] addr,
    output region_t     region_q,
    output logic        hit
);

    logic [5:0]  exp_w;
    logic [31:0] low_mask;
    logic [2:0]  sub_idx;
    logic        in_block;

    // Register storage: base and attribute fields, cleared on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= '0;
        end else begin
            if (base_we) region_q.base <= base_d;
            if (attr_we) begin
                region_q.xn   <= xn_d;
                region_q.ap   <= ap_d;
                region_q.srd  <= srd_d;
                region_q.size <= size_d;
                region_q.en   <= en_d;
            end
        end
    end

    // Match: upper address bits against base, then slice-disable lookup
    always_comb begin
        exp_w    = {1'b0, region_q.size} + 6'd1;
        low_mask = (32'd1 << exp_w) - 32'd1;
        in_block = ((addr ^ {region_q.base, 5'b0}) & ~low_mask) == 32'd0;
        sub_idx  = 3'(addr >> (region_q.size - 5'd2));
        hit      = region_q.en && (region_q.size >= MIN_SIZE_CODE)
                   && in_block && !region_q.srd[sub_idx];
    end

endmodule

// File: rtl/mpu_hit_select.sv
// Picks the highest-numbered matching region and forwards its permission
// code and execute-never flag.
// Assumes: hits are already qualified by enable, size and slice mask.
module mpu_hit_select #(
    parameter int NUM_REGIONS = 8
) (
    input  logic [NUM_REGIONS-1:0]      hits,
    input  logic [NUM_REGIONS-1:0][2:0] ap_vec,
    input  logic [NUM_REGIONS-1:0]      xn_vec,
    output logic                        win_hit,
    output logic [2:0]                  win_ap,
    output logic                        win_xn
);

    // Ascending scan so a later (higher) index overrides earlier matches
    always_comb begin
        win_hit = 1'b0;
        win_ap  = 3'b000;
        win_xn  = 1'b0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (hits[i]) begin
                win_hit = 1'b1;
                win_ap  = ap_vec[i];
                win_xn  = xn_vec[i];
            end
        end
    end

endmodule

// File: rtl/mpu_access_judge.sv
// Final permit/fault decision from control bits, access flags and the
// winning region.
// Assumes: a fetch is treated as a read; the write flag is then unused.
module mpu_access_judge
    import mpu_guard_pkg::*;
(
    input  logic [2:0] ctrl,
    input  logic       in_handler,
    input  logic       priv,
    input  logic       write,
    input  logic       fetch,
    input  logic       win_hit,
    input  logic [2:0] win_ap,
    input  logic       win_xn,
    output logic       permit
);

    logic       bypass;
    logic [1:0] rights;

    // Decision: bypass, background fallback, or region rights
    always_comb begin
        bypass = !ctrl[0] || (in_handler && !ctrl[1]);
        rights = ap_rights(win_ap, priv);
        if (bypass)        permit = 1'b1;
        else if (!win_hit) permit = priv && ctrl[2];
        else if (fetch)    permit = rights[1] && !win_xn;
        else if (write)    permit = rights[0];
        else               permit = rights[1];
    end

endmodule

// File: rtl/mpu_region_guard.sv
// Top of the memory protection checker: register decode and readback,
// a bank of region slots, priority selection and the access decision.
// Assumes: NUM_REGIONS between 2 and 16; one register access per cycle.
module mpu_region_guard
    import mpu_guard_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_sel,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] acc_addr,
    input  logic        acc_write,
    input  logic        acc_fetch,
    input  logic        acc_priv,
    input  logic        acc_in_handler,
    output logic        acc_permit
);

    localparam int         IDX_W = $clog2(NUM_REGIONS);
    localparam logic [7:0] N8    = 8'(NUM_REGIONS);

    logic [2:0] ctrl_q;
    logic [7:0] rnum_q;
    logic       base_wr, attr_wr;
    logic [7:0] base_tgt;
    region_t    regions_q [NUM_REGIONS];
    region_t    sel_region;
    logic [NUM_REGIONS-1:0]      hits;
    logic [NUM_REGIONS-1:0][2:0] ap_vec;
    logic [NUM_REGIONS-1:0]      xn_vec;
    logic       win_hit, win_xn;
    logic [2:0] win_ap;

    // Write decode: base target comes from the write itself when flagged valid
    always_comb begin
        base_wr  = reg_wr && (reg_sel == SEL_BASE);
        attr_wr  = reg_wr && (reg_sel == SEL_ATTR);
        base_tgt = reg_wdata[4] ? {4'b0, reg_wdata[3:0]} : rnum_q;
    end

    // Control and region number registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 3'b000;
            rnum_q <= 8'd0;
        end else begin
            if (reg_wr && reg_sel == SEL_CTRL) ctrl_q <= reg_wdata[2:0];
            if (reg_wr && reg_sel == SEL_RNUM) rnum_q <= reg_wdata[7:0];
            else if (base_wr && reg_wdata[4])  rnum_q <= {4'b0, reg_wdata[3:0]};
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
            mpu_region_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .base_we  (base_wr && base_tgt == 8'(g)),
                .attr_we  (attr_wr && rnum_q == 8'(g)),
                .base_d   (reg_wdata[31:5]),
                .xn_d     (reg_wdata[28]),
                .ap_d     (reg_wdata[26:24]),
                .srd_d    (reg_wdata[15:8]),
                .size_d   (reg_wdata[5:1]),
                .en_d     (reg_wdata[0]),
                .addr     (acc_addr),
                .region_q (regions_q[g]),
                .hit      (hits[g])
            );
            assign ap_vec[g] = regions_q[g].ap;
            assign xn_vec[g] = regions_q[g].xn;
        end
    endgenerate

    mpu_hit_select #(.NUM_REGIONS(NUM_REGIONS)) u_select (
        .hits    (hits),
        .ap_vec  (ap_vec),
        .xn_vec  (xn_vec),
        .win_hit (win_hit),
        .win_ap  (win_ap),
        .win_xn  (win_xn)
    );

    mpu_access_judge u_judge (
        .ctrl       (ctrl_q),
        .in_handler (acc_in_handler),
        .priv       (acc_priv),
        .write      (acc_write),
        .fetch      (acc_fetch),
        .win_hit    (win_hit),
        .win_ap     (win_ap),
        .win_xn     (win_xn),
        .permit     (acc_permit)
    );

    // Readback: region registers follow the region number; none beyond the count
    always_comb begin
        sel_region = (rnum_q < N8) ? regions_q[rnum_q[IDX_W-1:0]] : '0;
        case (reg_sel)
            SEL_TYPE: reg_rdata = {16'b0, N8, 8'b0};
            SEL_CTRL: reg_rdata = {29'b0, ctrl_q};
            SEL_RNUM: reg_rdata = {24'b0, rnum_q};
            SEL_BASE: reg_rdata = {sel_region.base, 1'b0, rnum_q[3:0]};
            SEL_ATTR: reg_rdata = {3'b0, sel_region.xn, 1'b0, sel_region.ap, 8'b0,
                                   sel_region.srd, 2'b0, sel_region.size, sel_region.en};
            default:  reg_rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/mpu_guard_checker.sv
// Property checker for mpu_region_guard, attached by bind below.
// Assumes: inputs defined whenever reset is released.
module mpu_guard_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  ctrl_q,
    input logic [7:0]  rnum_q,
    input logic [2:0]  reg_sel,
    input logic        reg_wr,
    input logic [31:0] reg_wdata,
    input logic        acc_fetch,
    input logic        acc_priv,
    input logic        acc_in_handler,
    input logic        acc_permit,
    input logic        win_hit,
    input logic [2:0]  win_ap,
    input logic        win_xn
);

    logic checking;
    assign checking = ctrl_q[0] && !(acc_in_handler && !ctrl_q[1]);

    p_off_permit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[0] |-> acc_permit);

    p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd1) |=> ctrl_q == $past(reg_wdata[2:0]));

    p_valid_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 3'd3 && reg_wdata[4]) |=> rnum_q == {4'b0, $past(reg_wdata[3:0])});

    p_noaccess_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (checking && win_hit && win_ap == 3'b000) |-> !acc_permit);

    p_xn_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (checking && acc_fetch && win_hit && win_xn) |-> !acc_permit);

    p_nomatch_user_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (checking && !win_hit && !acc_priv) |-> !acc_permit);

    p_handler_bypass_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_in_handler && !ctrl_q[1]) |-> acc_permit);

endmodule

bind mpu_region_guard mpu_guard_checker u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctrl_q         (ctrl_q),
    .rnum_q         (rnum_q),
    .reg_sel        (reg_sel),
    .reg_wr         (reg_wr),
    .reg_wdata      (reg_wdata),
    .acc_fetch      (acc_fetch),
    .acc_priv       (acc_priv),
    .acc_in_handler (acc_in_handler),
    .acc_permit     (acc_permit),
    .win_hit        (win_hit),
    .win_ap         (win_ap),
    .win_xn         (win_xn)
);

// File: tb/tb_mpu_region_guard.sv
// Bench: four-region configuration, expected results from a bench-side model
// of the requirements, swept over permission codes, sizes and slices.
module tb_mpu_region_guard;

    localparam int NR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic [31:0] acc_addr = 32'd0;
    logic        acc_write = 1'b0, acc_fetch = 1'b0, acc_priv = 1'b0, acc_in_handler = 1'b0;
    logic        acc_permit;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_base [NR];
    logic [4:0]  m_size [NR];
    logic [7:0]  m_srd  [NR];
    logic [2:0]  m_ap   [NR];
    logic        m_xn   [NR];
    logic        m_en   [NR];
    logic [2:0]  m_ctrl;
    logic [31:0] rv;

    always #4 clk = ~clk;

    mpu_region_guard #(.NUM_REGIONS(NR)) dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_fetch(acc_fetch), .acc_priv(acc_priv),
        .acc_in_handler(acc_in_handler), .acc_permit(acc_permit)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected decision, built from the requirement text
    function automatic logic exp_permit(input logic [31:0] a, input logic w, input logic f,
                                        input logic p, input logic h);
        logic [32:0] span, start;
        logic hit_f, rd, wr, xn;
        logic [2:0] ap;
        int sub;
        if (!m_ctrl[0] || (h && !m_ctrl[1])) return 1'b1;
        hit_f = 1'b0; ap = 3'd0; xn = 1'b0;
        for (int r = 0; r < NR; r++) begin
            if (m_en[r] && m_size[r] >= 5'd4) begin
                span  = 33'd1 << (m_size[r] + 1);
                start = {1'b0, m_base[r]} & ~(span - 33'd1);
                if ({1'b0, a} >= start && {1'b0, a} < start + span) begin
                    sub = int'(({1'b0, a} - start) / (span >> 3));
                    if (!m_srd[r][sub]) begin hit_f = 1'b1; ap = m_ap[r]; xn = m_xn[r]; end
                end
            end
        end
        if (!hit_f) return p && m_ctrl[2];
        case (ap)
            3'd1:       begin rd = p;    wr = p;    end
            3'd2:       begin rd = 1'b1; wr = p;    end
            3'd3:       begin rd = 1'b1; wr = 1'b1; end
            3'd5:       begin rd = p;    wr = 1'b0; end
            3'd6, 3'd7: begin rd = 1'b1; wr = 1'b0; end
            default:    begin rd = 1'b0; wr = 1'b0; end
        endcase
        if (f) return rd && !xn;
        return w ? wr : rd;
    endfunction

    task automatic wr(input logic [2:0] s, input logic [31:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [31:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_ctrl(input logic [2:0] c);
        wr(3'd1, {29'b0, c});
        m_ctrl = c;
    endtask

    task automatic prog(input int idx, input logic [31:0] base, input logic [4:0] size,
                        input logic [7:0] srd, input logic [2:0] ap, input logic xn, input logic en);
        wr(3'd3, {base[31:5], 1'b1, 4'(idx)});
        wr(3'd4, {3'b0, xn, 1'b0, ap, 8'b0, srd, 2'b0, size, en});
        m_base[idx] = {base[31:5], 5'b0};
        m_size[idx] = size; m_srd[idx] = srd; m_ap[idx] = ap; m_xn[idx] = xn; m_en[idx] = en;
    endtask

    task automatic clear_all();
        for (int r = 0; r < NR; r++) prog(r, 32'd0, 5'd0, 8'd0, 3'd0, 1'b0, 1'b0);
    endtask

    task automatic probe(input string tag, input logic [31:0] a, input logic w, input logic f,
                         input logic p, input logic h);
        acc_addr = a; acc_write = w; acc_fetch = f; acc_priv = p; acc_in_handler = h;
        #1;
        chk(tag, 32'(acc_permit), 32'(exp_permit(a, w, f, p, h)));
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        for (int r = 0; r < NR; r++) begin
            m_base[r] = 0; m_size[r] = 0; m_srd[r] = 0; m_ap[r] = 0; m_xn[r] = 0; m_en[r] = 0;
        end
        m_ctrl = 3'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state and disabled unit
        rd(3'd1, rv); chk("R1 control after reset", rv, 32'd0);
        rd(3'd2, rv); chk("R1 region number after reset", rv, 32'd0);
        for (int r = 0; r < NR; r++) begin
            wr(3'd2, 32'(r));
            rd(3'd4, rv); chk("R1 attributes after reset", rv, 32'd0);
        end
        probe("R1 disabled permits user write", 32'h0000_1234, 1'b1, 1'b0, 1'b0, 1'b0);
        probe("R1 disabled permits user fetch", 32'hFFFF_FFF0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R2: type register
        rd(3'd0, rv); chk("R2 type register", rv, 32'h0000_0400);

        // R3: control readback
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1, rv); chk("R3 control readback", rv, 32'd7);
        set_ctrl(3'd0);

        // R4: base register targeting
        wr(3'd2, 32'd2);
        wr(3'd3, 32'hFFFF_FFE0);
        m_base[2] = 32'hFFFF_FFE0;
        rd(3'd3, rv); chk("R4 base via region number", rv, 32'hFFFF_FFE2);
        wr(3'd3, 32'h2000_0011);
        m_base[1] = 32'h2000_0000;
        rd(3'd2, rv); chk("R4 valid index copied", rv, 32'd1);
        rd(3'd3, rv); chk("R4 base via valid index", rv, 32'h2000_0001);
        wr(3'd2, 32'd2);
        rd(3'd3, rv); chk("R4 other region untouched", rv, 32'hFFFF_FFE2);
        wr(3'd3, 32'h0000_5019);
        rd(3'd2, rv); chk("R4 out-of-range index copied", rv, 32'd9);
        rd(3'd4, rv); chk("R4 out-of-range attributes", rv, 32'd0);
        wr(3'd2, 32'd1);
        rd(3'd3, rv); chk("R4 out-of-range write ignored", rv, 32'h2000_0001);

        // R5: attribute field layout
        wr(3'd2, 32'd3);
        wr(3'd4, 32'hFFFF_FFFF);
        rd(3'd4, rv); chk("R5 attribute readback mask", rv, 32'h1700_FF3F);
        wr(3'd4, 32'h0200_A50F);
        rd(3'd4, rv); chk("R5 attribute fields", rv, 32'h0200_A50F);
        clear_all();

        // R8 R9 R13: permission code sweep
        set_ctrl(3'd1);
        for (int ap = 0; ap < 8; ap++) begin
            for (int xn = 0; xn < 2; xn++) begin
                prog(0, 32'h0000_8000, 5'd7, 8'h00, 3'(ap), 1'(xn), 1'b1);
                for (int p = 0; p < 2; p++) begin
                    probe("R8 read",  32'h0000_8040, 1'b0, 1'b0, 1'(p), 1'b0);
                    probe("R8 write", 32'h0000_8040, 1'b1, 1'b0, 1'(p), 1'b0);
                    probe("R9 fetch", 32'h0000_8040, 1'b0, 1'b1, 1'(p), 1'b0);
                    probe("R13 fetch with write flag", 32'h0000_80FC, 1'b1, 1'b1, 1'(p), 1'b0);
                end
            end
        end
        clear_all();

        // R7: slice-disable sweep
        prog(1, 32'h0000_1000, 5'd7, 8'h5A, 3'd3, 1'b0, 1'b1);
        for (int a = 32'h0FE0; a < 32'h1120; a += 16)
            probe("R7 slice sweep", 32'(a), 1'b0, 1'b0, 1'b0, 1'b0);
        clear_all();

        // R6: size sweep with low base bits ignored
        for (int s = 0; s < 13; s++) begin
            prog(2, 32'h0001_0060, 5'(s), 8'h00, 3'd3, 1'b0, 1'b1);
            probe("R6 size", 32'h0000_FFFF, 1'b0, 1'b0, 1'b0, 1'b0);
            probe("R6 size", 32'h0001_0000, 1'b0, 1'b0, 1'b0, 1'b0);
            probe("R6 size", 32'h0001_005F, 1'b0, 1'b0, 1'b0, 1'b0);
            probe("R6 size", 32'h0001_0060, 1'b0, 1'b0, 1'b0, 1'b0);
            probe("R6 size", 32'h0001_007F, 1'b0, 1'b0, 1'b0, 1'b0);
            probe("R6 size", 32'h0001_0080, 1'b0, 1'b0, 1'b0, 1'b0);
            probe("R6 size", 32'h0001_00FF, 1'b0, 1'b0, 1'b0, 1'b0);
            probe("R6 size", 32'h0001_0100, 1'b0, 1'b0, 1'b0, 1'b0);
            probe("R6 size", 32'h0001_1FFF, 1'b0, 1'b0, 1'b0, 1'b0);
            probe("R6 size", 32'h0001_2000, 1'b0, 1'b0, 1'b0, 1'b0);
        end
        clear_all();

        // R10: overlap priority
        prog(1, 32'h0002_0000, 5'd11, 8'h00, 3'd3, 1'b0, 1'b1);
        prog(3, 32'h0002_0400, 5'd7,  8'h00, 3'd0, 1'b0, 1'b1);
        prog(2, 32'h0002_0400, 5'd8,  8'h00, 3'd6, 1'b0, 1'b1);
        acc_addr = 32'h0002_0410; acc_write = 1'b1; acc_fetch = 1'b0; acc_priv = 1'b0; acc_in_handler = 1'b0;
        #1; chk("R10 region 3 over 2 and 1", 32'(acc_permit), 32'd0);
        acc_addr = 32'h0002_0510; acc_write = 1'b1;
        #1; chk("R10 region 2 over 1 write", 32'(acc_permit), 32'd0);
        acc_write = 1'b0;
        #1; chk("R10 region 2 over 1 read", 32'(acc_permit), 32'd1);
        acc_addr = 32'h0002_0610; acc_write = 1'b1;
        #1; chk("R10 region 1 alone", 32'(acc_permit), 32'd1);
        prog(0, 32'h0002_0000, 5'd11, 8'h00, 3'd0, 1'b0, 1'b1);
        acc_addr = 32'h0002_0010; acc_write = 1'b1; acc_priv = 1'b0;
        #1; chk("R10 region 1 over region 0", 32'(acc_permit), 32'd1);
        clear_all();

        // R11: no match with and without background
        set_ctrl(3'd1);
        probe("R11 privileged miss, no background", 32'h9000_0000, 1'b0, 1'b0, 1'b1, 1'b0);
        set_ctrl(3'd5);
        probe("R11 privileged miss, background", 32'h9000_0000, 1'b1, 1'b0, 1'b1, 1'b0);
        probe("R11 privileged fetch, background", 32'h9000_0000, 1'b0, 1'b1, 1'b1, 1'b0);
        probe("R11 user miss, background", 32'h9000_0000, 1'b0, 1'b0, 1'b0, 1'b0);

        // R12: fault-handler bypass
        set_ctrl(3'd1);
        probe("R12 handler bypass", 32'h9000_0000, 1'b1, 1'b0, 1'b0, 1'b1);
        set_ctrl(3'd3);
        probe("R12 handler checked", 32'h9000_0000, 1'b1, 1'b0, 1'b0, 1'b1);

        // R1: disabling again permits everything
        set_ctrl(3'd0);
        probe("R1 disabled after use", 32'h9000_0000, 1'b1, 1'b0, 1'b0, 1'b0);

        summary();
    end

endmodule